// File: doc/BRIEF.md
# Serial Calendar-Clock Register Slave

This block is the host-facing side of a calendar clock. It holds the clock's register map behind a four-wire serial link, with a chip enable, a serial clock, data in and data out. The map has seven time registers (seconds, minutes, hours, day of week, date, month, year), two banks of four alarm registers, a control register, a status register, a charger register and a 32-byte user RAM window. Timekeeping, alarm matching, interrupts and the charger function sit outside this block. It only stores and returns the bytes.

A transaction runs while the chip enable is high. The first byte is an address byte. Bit 7 of that byte sets the direction: 1 writes and 0 reads. Bits 6:0 give the starting register. Every byte after it in the same enable window moves the pointer one step. The pointer wraps inside the 32-byte block it started in.

Bit 6 of the control register (address 0x0F) is a write-protect bit. While it is set, every write is dropped except a write to the control register itself.

The serial pins go through a synchronizer into the system clock domain. The serial clock must therefore run several times slower than `clk`.

Top module: `rtc_spi_regs`

## Requirements
- R1: After reset every register reads 0x00, except control (0x0F), which reads 0x40. Data out is low.
- R2: The link uses mode 3 with MSB first.
  - Chip enable is active high. A rise starts a transaction and a fall ends it.
  - Data in is sampled on rising serial-clock edges.
  - Read data changes only after a rising edge and is stable by the next one.
  - The first byte after enable is the address byte. Bit 7 = 1 means write and bit 7 = 0 means read.
- R3: A read returns the current byte of the addressed register. Addresses 0x12–0x1F and 0x40–0x7F read as 0x00.
- R4: A write stores the data byte into the addressed register. The write happens when the byte's eighth bit is sampled and write protect is clear.
- R5: Further bytes in one enable window go to, or come from, consecutive addresses.
- R6: The burst pointer keeps address bits 6:5 and increments bits 4:0. Address 0x1F is followed by 0x00, and 0x3F is followed by 0x20.
- R7: While control bit 6 is 1, writes to every address except 0x0F are ignored. Writes to 0x0F always take effect, so writing 0x00 there clears protection.
- R8: Writes to 0x12–0x1F and to 0x40–0x7F have no effect.
- R9: Data out is low while enable is low. A byte cut short by the fall of enable is discarded and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs | input | 1 | Chip enable, active high |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial data out of the block, low when idle |

## Verification
The bench keeps its own byte array and pointer model. It exercises the corner cases where a faulty design would go visibly wrong:
- **Write protect.** A write while protect is set must leave the target unchanged. A faulty gate would let the write land, or would lock the control register so that protection can never be cleared.
- **Block wrap.** Bursts cross 0x3F and 0x1F. A pointer that carries into bit 5 would spill user-RAM data into the time registers.
- **Cut-off byte.** Enable is dropped after four data bits. A design that writes on a partial byte would corrupt the target.
- **Unmapped space.** Accesses to unmapped space must return zeros. Aliased decoding would instead echo another register.
- **First read bit.** Each read byte is compared bit for bit. Loading read data one edge late shows up as every byte shifted by one bit.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_q,
  output logic sdi_q,
  output logic sck_rise,
  output logic cs_edge
);
  logic [STAGES-1:0] cs_sh, sck_sh, sdi_sh;
  logic              sck_d, cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh  <= '0;
      sck_sh <= '1;
      sdi_sh <= '0;
      sck_d  <= 1'b1;
      cs_d   <= 1'b0;
    end else begin
      cs_sh  <= {cs_sh[STAGES-2:0], cs_i};
      sck_sh <= {sck_sh[STAGES-2:0], sck_i};
      sdi_sh <= {sdi_sh[STAGES-2:0], sdi_i};
      sck_d  <= sck_sh[STAGES-1];
      cs_d   <= cs_sh[STAGES-1];
    end
  end

  assign cs_q     = cs_sh[STAGES-1];
  assign sdi_q    = sdi_sh[STAGES-1];
  assign sck_rise = sck_sh[STAGES-1] & ~sck_d;
  assign cs_edge  = cs_q ^ cs_d;
endmodule

// File: rtl/rtc_spi_shift.sv
module rtc_spi_shift
  import rtc_spi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic       sdi,
  input  byte_t      load_val,
  output logic       byte_done,
  output byte_t      rx_byte,
  output logic       tx_msb,
  output logic [2:0] bit_cnt
);
  logic [6:0] rx_sh;
  byte_t      tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
    end else if (clr) begin
      bit_cnt <= '0;
      tx_sh   <= '0;
    end else if (step) begin
      rx_sh   <= {rx_sh[5:0], sdi};
      bit_cnt <= bit_cnt + 3'd1;
      tx_sh   <= (bit_cnt == 3'd7) ? load_val : {tx_sh[6:0], 1'b0};
    end
  end

  assign byte_done = step && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, sdi};
  assign tx_msb    = tx_sh[7];
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_spi_pkg::*;
#(
  parameter int   ADDR_W    = 7,
  parameter int   CORE_REGS = 18,
  parameter int   RAM_BASE  = 32,
  parameter int   RAM_BYTES = 32,
  parameter int   CTRL_ADDR = 15,
  parameter int   WP_BIT    = 6,
  parameter byte_t CTRL_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_data,
  output logic              wp_on
);
  localparam int CI_W = $clog2(CORE_REGS);
  localparam int RI_W = $clog2(RAM_BYTES);

  byte_t core [CORE_REGS];
  byte_t ram  [RAM_BYTES];

  logic w_core, w_ram, w_allow, r_core, r_ram;

  assign wp_on   = core[CTRL_ADDR][WP_BIT];
  assign w_core  = int'(wr_addr) < CORE_REGS;
  assign w_ram   = int'(wr_addr) >= RAM_BASE && int'(wr_addr) < RAM_BASE + RAM_BYTES;
  assign w_allow = wr_en && (int'(wr_addr) == CTRL_ADDR || !wp_on);
  assign r_core  = int'(rd_addr) < CORE_REGS;
  assign r_ram   = int'(rd_addr) >= RAM_BASE && int'(rd_addr) < RAM_BASE + RAM_BYTES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CORE_REGS; i++) core[i] <= (i == CTRL_ADDR) ? CTRL_RST : '0;
      for (int j = 0; j < RAM_BYTES; j++) ram[j] <= '0;
    end else if (w_allow) begin
      if (w_core) core[wr_addr[CI_W-1:0]] <= wr_data;
      if (w_ram)  ram[wr_addr[RI_W-1:0]]  <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (r_core)     rd_data = core[rd_addr[CI_W-1:0]];
    else if (r_ram) rd_data = ram[rd_addr[RI_W-1:0]];
  end
endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
  import rtc_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int BLK_W       = 5,
  parameter int CORE_REGS   = 18,
  parameter int RAM_BASE    = 32,
  parameter int RAM_BYTES   = 32,
  parameter int CTRL_ADDR   = 15,
  parameter int WP_BIT      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs,
  input  logic spi_sck,
  input  logic spi_sdi,
  output logic spi_sdo
);
  logic cs_q, sdi_q, sck_rise, cs_edge, step, clr;
  logic byte_done, tx_msb, wr_dir, wr_en, wp_on, is_read;
  logic [2:0] bit_cnt;
  byte_t rx_byte, rd_data, load_val;
  phase_e phase;
  logic [ADDR_W-1:0] ptr, next_ptr, rd_addr;

  rtc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(spi_cs), .sck_i(spi_sck), .sdi_i(spi_sdi),
    .cs_q(cs_q), .sdi_q(sdi_q), .sck_rise(sck_rise), .cs_edge(cs_edge)
  );

  assign step = sck_rise & cs_q;
  assign clr  = cs_edge | ~cs_q;

  rtc_spi_shift u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .sdi(sdi_q),
    .load_val(load_val), .byte_done(byte_done), .rx_byte(rx_byte),
    .tx_msb(tx_msb), .bit_cnt(bit_cnt)
  );

  assign next_ptr = {ptr[ADDR_W-1:BLK_W], ptr[BLK_W-1:0] + 1'b1};
  assign rd_addr  = (phase == PH_ADDR) ? rx_byte[ADDR_W-1:0] : next_ptr;
  assign is_read  = (phase == PH_ADDR) ? !rx_byte[7] : !wr_dir;
  assign load_val = is_read ? rd_data : '0;
  assign wr_en    = byte_done && (phase == PH_DATA) && wr_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_ADDR;
      wr_dir <= 1'b0;
      ptr    <= '0;
    end else if (clr) begin
      phase  <= PH_ADDR;
    end else if (byte_done) begin
      if (phase == PH_ADDR) begin
        phase  <= PH_DATA;
        wr_dir <= rx_byte[7];
        ptr    <= rx_byte[ADDR_W-1:0];
      end else begin
        ptr    <= next_ptr;
      end
    end
  end

  rtc_regfile #(
    .ADDR_W(ADDR_W), .CORE_REGS(CORE_REGS), .RAM_BASE(RAM_BASE),
    .RAM_BYTES(RAM_BYTES), .CTRL_ADDR(CTRL_ADDR), .WP_BIT(WP_BIT), .CTRL_RST(8'h40)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(rx_byte),
    .rd_addr(rd_addr), .rd_data(rd_data), .wp_on(wp_on)
  );

  assign spi_sdo = cs_q & tx_msb;
endmodule

// File: rtl/rtc_spi_regs_chk.sv
module rtc_spi_regs_chk #(
  parameter int ADDR_W    = 7,
  parameter int BLK_W     = 5,
  parameter int CTRL_ADDR = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_q,
  input logic [2:0]        bit_cnt,
  input logic              in_data,
  input logic              data_done,
  input logic [ADDR_W-1:BLK_W] ptr_blk,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_wp,
  input logic              wp_on
);
  // R9
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |=> bit_cnt == 3'd0);

  // R2
  address_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |=> !in_data);

  // R6
  burst_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && in_data) |=> ptr_blk == $past(ptr_blk));

  // R7
  wp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == CTRL_ADDR && wr_wp) |=> wp_on);

  // R7
  wp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) == CTRL_ADDR && !wr_wp) |=> !wp_on);
endmodule

bind rtc_spi_regs rtc_spi_regs_chk #(
  .ADDR_W(ADDR_W), .BLK_W(BLK_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .bit_cnt(bit_cnt),
  .in_data(phase == rtc_spi_pkg::PH_DATA), .data_done(byte_done),
  .ptr_blk(ptr[ADDR_W-1:BLK_W]), .wr_en(wr_en), .wr_addr(ptr),
  .wr_wp(rx_byte[WP_BIT]), .wp_on(wp_on)
);

// File: tb/rtc_spi_regs_test.sv
module rtc_spi_regs_test;
  localparam int H = 4;

  logic clk = 0, rst_n = 0, cs = 0, sck = 1, sdi = 0;
  logic sdo;
  int tests = 0, fails = 0, idle_cnt = 0;
  logic [7:0] mdl [128];
  bit done = 0;

  rtc_spi_regs uut (.clk(clk), .rst_n(rst_n), .spi_cs(cs), .spi_sck(sck),
                    .spi_sdi(sdi), .spi_sdo(sdo));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // R9: data out must be low once enable has been low for a few clocks
  always @(negedge clk) begin
    if (rst_n && !cs) idle_cnt++; else idle_cnt = 0;
    if (idle_cnt >= 4) check("R9 idle sdo", {7'd0, sdo}, 8'h00);
  end

  function automatic bit mapped(input int a);
    return a < 18 || (a >= 32 && a < 64);
  endfunction

  function automatic int step_ptr(input int a);
    return (a & 8'h60) | ((a + 1) & 8'h1F);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 0; sdi = tx[7-i];
      wclk(H);
      rx[7-i] = sdo;
      sck = 1;
      wclk(H);
    end
  endtask

  task automatic cs_on();  cs = 1; wclk(H); endtask
  task automatic cs_off(); wclk(H); cs = 0; wclk(3*H); endtask

  task automatic wr_burst(input int a, input logic [7:0] d [$]);
    logic [7:0] rx;
    int p = a;
    cs_on();
    xfer(8'h80 | a[6:0], 8, rx);
    foreach (d[k]) begin
      xfer(d[k], 8, rx);
      if (mapped(p) && (p == 15 || !mdl[15][6])) mdl[p] = d[k];
      p = step_ptr(p);
    end
    cs_off();
  endtask

  task automatic rd_burst(input string req, input int a, input int n);
    logic [7:0] rx;
    int p = a;
    cs_on();
    xfer({1'b0, a[6:0]}, 8, rx);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, rx);
      check(req, rx, mapped(p) ? mdl[p] : 8'h00);
      p = step_ptr(p);
    end
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 128; i++) mdl[i] = 8'h00;
    mdl[15] = 8'h40;
    wclk(5); rst_n = 1; wclk(5);
    // R1: reset values, data out low
    check("R1 sdo after reset", {7'd0, sdo}, 8'h00);
    rd_burst("R1 R5 reset map", 0, 18);
    check("R1 control reset", mdl[15], 8'h40);
    // R7: protected write dropped
    wr_burst(0, '{8'h59});
    rd_burst("R7 protected write", 0, 1);
    // R7: control writable under protect, clears it
    wr_burst(15, '{8'h00});
    rd_burst("R7 control clear", 15, 1);
    // R4 R5: burst write of time registers then burst read
    wr_burst(0, '{8'h45, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99});
    rd_burst("R4 R5 time burst", 0, 7);
    // R4 R3: single write/read to an alarm register
    wr_burst(11, '{8'hA5});
    rd_burst("R3 R4 single alarm", 11, 1);
    // R8 R3: unmapped space
    wr_burst(8'h15, '{8'hAA});
    wr_burst(8'h45, '{8'h55});
    rd_burst("R8 unmapped low", 8'h15, 1);
    rd_burst("R8 unmapped high", 8'h45, 1);
    // R6: wrap within user RAM and within the register block
    wr_burst(8'h3E, '{8'h11, 8'h22, 8'h33, 8'h44});
    rd_burst("R6 RAM wrap", 8'h3E, 4);
    rd_burst("R6 reg block wrap", 8'h1F, 2);
    rd_burst("R6 no spill", 8'h00, 1);
    // R9: byte cut short by enable fall writes nothing
    cs_on();
    xfer(8'hB0, 8, rx);
    xfer(8'hFF, 4, rx);
    sck = 1;
    cs_off();
    rd_burst("R9 partial byte", 8'h30, 1);
    // R2: mixed bit patterns MSB first
    wr_burst(8'h28, '{8'h80, 8'h01, 8'h5A});
    rd_burst("R2 bit order", 8'h28, 3);
    // R7: burst that sets protect then tries the status register
    wr_burst(15, '{8'h40, 8'h77});
    rd_burst("R7 protect mid burst", 15, 2);
    wr_burst(8'h21, '{8'hFF});
    rd_burst("R7 RAM protected", 8'h21, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule